// File: doc/BRIEF.md
# Write Completion Status Detector

This block runs on the host side of a byte-wide nonvolatile memory. Once a program or erase operation has been launched on the memory, the engine takes over. It reads the target location over a simple request/response read port and decides from the returned bytes when the operation has finished. It then reports whether the stored byte matches what was meant to be written.

Three detection methods can be selected. Complement polling watches bit 7, which reads inverted while the memory is busy. Toggle detection watches bit 6, which flips on every read while the memory is busy. The third method waits for two equal successive reads. The memory may finish between two reads, so a stopped status can come with wrong data. When that happens the engine takes two further confirming reads before it accepts or rejects the result. A cycle timeout guarantees that every accepted start ends in exactly one completion report. For erase checks the expected byte is FFH. Complement polling only gives a meaningful answer on a location that was erased before it was programmed.

Top module: `wcs_detect`

## Requirements
- R1: After reset the engine is idle, with busy, rd_req and done all low.
- R2: An accepted start makes the engine issue reads of the latched address on rd_addr. Each read is a one-cycle rd_req pulse. No further pulse is issued until the matching rd_ack has arrived.
- R3: Method code 0 (complement polling) treats the status as stopped on the first returned byte whose bit 7 equals bit 7 of the expected data.
- R4: Method code 1 (toggle detection) treats the status as stopped when bit 6 of a returned byte equals bit 6 of the byte returned just before it. The first read of an operation never counts as stopped.
- R5: Method codes 2 and 3 (successive reads) treat the status as stopped when a returned byte equals the whole byte returned just before it.
- R6: If the byte read at the stop equals the expected data, the engine ends with done high and pass high, with no further read.
- R7: If the byte read at the stop differs from the expected data, exactly two confirming reads follow. If both return the expected data, the result is pass. The first confirming read that differs ends the operation at once with pass low.
- R8: If no result is reached, done rises with pass low exactly TMO_CYC cycles after the start is accepted.
- R9: done is high for one cycle per operation. pass keeps its value until the next accepted start.
- R10: A start pulse that arrives while busy is high has no effect on the running operation or on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a detection run (taken only when idle) |
| method | input | 2 | 0 bit-7 polling, 1 bit-6 toggle, 2/3 successive equal reads |
| addr | input | AW | Location that was written |
| exp_data | input | 8 | Byte that should end up stored (FFH for erase) |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | 8 | Read response byte |
| busy | output | 1 | Detection run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result: 1 when the expected data was confirmed |

## Verification
The assertions assume that the read port answers each request exactly once. They also assume that rd_ack only rises on the cycle after an rd_req pulse, which is the single-outstanding, fixed-latency port the engine is built for. The bench memory model honours this by registering every request into an acknowledge one cycle later. Each response byte comes from a per-run script whose last entry repeats. Starts are driven on falling edges, and no stimulus ever acknowledges a read that was not requested.

// File: rtl/wcs_detect.sv
module wcs_detect #(
  parameter int AW      = 19,
  parameter int TMO_CYC = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    method,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    exp_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [7:0]    rd_data,
  output logic          busy,
  output logic          done,
  output logic          pass
);
  localparam int TW = $clog2(TMO_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t           st;
  logic [1:0]    mode_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    exp_q, prev_q;
  logic          have_prev, confirming;
  logic [1:0]    conf_left;
  logic [TW-1:0] tmo_cnt;
  logic          done_q, pass_q;
  logic          stopped, match, ack_now, tmo_hit, fin, fin_pass;

  assign busy    = (st != S_IDLE);
  assign rd_req  = (st == S_REQ);
  assign rd_addr = addr_q;
  assign done    = done_q;
  assign pass    = pass_q;
  assign match   = (rd_data == exp_q);
  assign ack_now = (st == S_WAIT) && rd_ack;
  assign tmo_hit = (tmo_cnt == TW'(TMO_CYC - 1));

  always_comb begin
    case (mode_q)
      2'd0:    stopped = (rd_data[7] == exp_q[7]);
      2'd1:    stopped = have_prev && (rd_data[6] == prev_q[6]);
      default: stopped = have_prev && (rd_data == prev_q);
    endcase
  end

  always_comb begin
    fin      = 1'b0;
    fin_pass = 1'b0;
    if (ack_now) begin
      if (confirming) begin
        if (!match) fin = 1'b1;
        else if (conf_left == 2'd1) begin
          fin      = 1'b1;
          fin_pass = 1'b1;
        end
      end else if (stopped && match) begin
        fin      = 1'b1;
        fin_pass = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      mode_q     <= 2'd0;
      addr_q     <= '0;
      exp_q      <= 8'h00;
      prev_q     <= 8'h00;
      have_prev  <= 1'b0;
      confirming <= 1'b0;
      conf_left  <= 2'd0;
      tmo_cnt    <= '0;
      done_q     <= 1'b0;
      pass_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          mode_q     <= method;
          addr_q     <= addr;
          exp_q      <= exp_data;
          have_prev  <= 1'b0;
          confirming <= 1'b0;
          conf_left  <= 2'd0;
          tmo_cnt    <= '0;
          pass_q     <= 1'b0;
          st         <= S_REQ;
        end
      end else begin
        tmo_cnt <= tmo_cnt + 1'b1;
        if (fin || tmo_hit) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
          pass_q <= fin && fin_pass;
        end else if (st == S_REQ) begin
          st <= S_WAIT;
        end else if (ack_now) begin
          st <= S_REQ;
          if (confirming) begin
            conf_left <= conf_left - 2'd1;
          end else if (stopped) begin
            confirming <= 1'b1;
            conf_left  <= 2'd2;
          end else begin
            prev_q    <= rd_data;
            have_prev <= 1'b1;
          end
        end
      end
    end
  end

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !rd_req); // R2
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> !rd_req); // R2
  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) rd_ack |-> $past(rd_req)); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (!busy || $stable(rd_addr))); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
  AST_PASS_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!done && !busy && !$rose(busy)) |-> $stable(pass)); // R9
  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (tmo_cnt < TW'(TMO_CYC))); // R8
  AST_CONF_RANGE: assert property (@(posedge clk) disable iff (!rst_n) confirming |-> (conf_left != 2'd0)); // R7
endmodule

// File: tb/sim_wcs_detect.sv
`timescale 1ns/1ps
module sim_wcs_detect;
  localparam int AW  = 19;
  localparam int TMO = 64;
  localparam int NV  = 11;

  // {method[2], exp[8], d0..d5[48], pass[1], reads[4]}
  localparam logic [62:0] VEC [NV] = '{
    {2'd0, 8'h5A, 48'hA5A55A5A5A5A, 1'b1, 4'd3},  // R3 R6
    {2'd0, 8'h5A, 48'hDA5B5A5A5A5A, 1'b1, 4'd4},  // R3 R7 race
    {2'd0, 8'h5A, 48'h4A4A4A4A4A4A, 1'b0, 4'd2},  // R7 fail
    {2'd1, 8'h5A, 48'h0040005A5A5A, 1'b1, 4'd5},  // R4 R6
    {2'd1, 8'h5A, 48'h0040405A5A5A, 1'b1, 4'd5},  // R4 R7
    {2'd1, 8'h5A, 48'h0040405A1111, 1'b0, 4'd5},  // R7 second confirm fails
    {2'd2, 8'h5A, 48'h125A5A5A5A5A, 1'b1, 4'd3},  // R5
    {2'd3, 8'hFF, 48'h77FFFFFFFFFF, 1'b1, 4'd3},  // R5 code 3, erase
    {2'd0, 8'hFF, 48'h007FFFFFFFFF, 1'b1, 4'd3},  // R3 erase
    {2'd2, 8'h5A, 48'h1234345A5A5A, 1'b1, 4'd5},  // R5 R7
    {2'd2, 8'h5A, 48'h123434343434, 1'b0, 4'd4}   // R7 fail
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rd_ack = 1'b0;
  logic [1:0] method = 2'd0;
  logic [AW-1:0] addr = '0;
  logic [7:0] exp_data = 8'h00, rd_data = 8'h00;
  logic rd_req, busy, done, pass;
  logic [AW-1:0] rd_addr;

  int checks = 0, fails = 0, cyc = 0, idx = 0, nreq = 0, addr_bad = 0;
  logic [7:0] seq [6];

  always #2 clk = ~clk;

  wcs_detect #(.AW(AW), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .method(method), .addr(addr),
    .exp_data(exp_data), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .busy(busy), .done(done), .pass(pass));

  always @(posedge clk) begin
    rd_ack <= rd_req;
    if (rd_req) begin
      rd_data <= seq[(idx > 5) ? 5 : idx];
      idx  <= idx + 1;
      nreq <= nreq + 1;
      if (rd_addr != addr) addr_bad <= addr_bad + 1;
    end
  end

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic load(input logic [47:0] d);
    for (int k = 0; k < 6; k++) seq[k] = d[47-8*k -: 8];
    idx = 0; nreq = 0; addr_bad = 0;
  endtask

  task automatic run(input logic [1:0] m, input logic [7:0] e, input logic [AW-1:0] a,
                     input bit spurious, output int n);
    method = m; exp_data = e; addr = a; start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 1000) begin
      @(negedge clk); n++;
      if (spurious && n == 3) begin
        start = 1'b1; method = 2'd0; exp_data = 8'h00; addr = a ^ 1;
      end else if (spurious && n == 4) begin
        start = 1'b0; method = m; exp_data = e; addr = a;
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 rd_req", rd_req, 0);
    chk("R1 done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      load(VEC[v][52:5]);
      run(VEC[v][62:61], VEC[v][60:53], AW'(19'h1000 + v), 1'b0, n);
      chk($sformatf("R6/R7 pass v%0d", v), pass, VEC[v][4]);
      chk($sformatf("R2 reads v%0d", v), nreq, VEC[v][3:0]);
      chk($sformatf("R2 addr v%0d", v), addr_bad, 0);
      @(negedge clk);
      chk($sformatf("R9 done width v%0d", v), done, 0);
      chk($sformatf("R9 pass held v%0d", v), pass, VEC[v][4]);
    end

    // R8: never stops (bit 7 always opposite of expected)
    load(48'h000000000000);
    run(2'd0, 8'hFF, 19'h00042, 1'b0, n);
    chk("R8 timeout cycles", n, TMO);
    chk("R8 timeout pass", pass, 0);
    @(negedge clk);

    // R10: start mid-run with other settings is ignored
    load(48'h0040005A5A5A);
    run(2'd1, 8'h5A, 19'h00777, 1'b1, n);
    chk("R10 pass", pass, 1);
    chk("R10 reads", nreq, 5);
    chk("R10 addr", addr_bad, 0);
    @(negedge clk);

    // R1: reset during a run returns to idle
    load(48'h000000000000);
    method = 2'd0; exp_data = 8'hFF; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 req after reset", rd_req, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule